// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Unit

This block sits in front of the core of an 8-bit processor and decides which of five interrupt request lines is serviced. Four lines have a fixed service address. The lowest line has no fixed address. Instead, the unit asks the core to take one instruction from the external bus and derives the target from it. The target may be a restart opcode that encodes a slot number, or a three-byte call whose two trailing bytes form the address.

The unit keeps a global enable and three individual mask bits. It chooses the highest eligible request and presents it to the core until the core acknowledges it. After that, it produces a one-cycle strobe together with the branch target. The strobe also tells the core to save the current program counter on the stack. Storing to the stack and executing instructions are the core's job.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the global enable is clear, all three individual masks are set, and `pend_o`, `src_o`, `ext_fetch_o`, `push_pc_o` and `vec_o` are all zero.
- R2: `req_i` bit 4 is the non-maskable line, bits 3, 2 and 1 are the three maskable fixed-vector lines, and bit 0 is the external-opcode line. Priority falls from bit 4 down to bit 0. Only the highest eligible line is granted, and `src_o` shows it as a one-hot bit in the same position.
- R3: Bit 4 is granted regardless of the global enable and the masks, and its target is 0024h.
- R4: The targets of bits 3, 2 and 1 are 003Ch, 0034h and 002Ch respectively.
- R5: A pulse on `ei_i` sets the global enable. A pulse on `di_i` clears it, and `di_i` wins when both are high. While the enable is clear, bits 3 to 0 are never granted.
- R6: When `mask_wr_i` is high, `mask_data_i` is loaded into the masks. In `mask_data_i`, bit 0 masks `req_i` bit 1, bit 1 masks `req_i` bit 2, bit 2 masks `req_i` bit 3, and 1 means masked. A masked line is not granted. Bit 0 of `req_i` is not affected by the masks.
- R7: While `pend_o` is high, `src_o` holds its value until `ack_i`, whatever the request lines do.
- R8: Acknowledging any maskable grant clears the global enable at that edge. Acknowledging bit 4 leaves the enable unchanged.
- R9: For a fixed-vector grant, `push_pc_o` is high for exactly the one cycle after the acknowledge, and `vec_o` carries the target during that cycle. At all other times `vec_o` is zero.
- R10: After a bit-0 grant is acknowledged, `ext_fetch_o` stays high until the opcode arrives with `bus_valid_i`. An opcode of the form 11nnn111 gives target n×8, and that target is issued with `push_pc_o` one cycle later.
- R11: Opcode CDh (call) makes the unit take two further valid bus bytes, low byte first. The target is {high, low} and is issued one cycle after the high byte.
- R12: Any other opcode drops the interrupt with no `push_pc_o`, returns the unit to idle, and leaves the global enable clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 5 | Request lines, bit 4 highest priority |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| mask_wr_i | input | 1 | Load individual masks |
| mask_data_i | input | 3 | New mask values, 1 = masked |
| ack_i | input | 1 | Core accepts the pending grant |
| bus_valid_i | input | 1 | External byte on `bus_data_i` is valid |
| bus_data_i | input | 8 | External opcode or address byte |
| pend_o | output | 1 | A grant is waiting for acknowledge |
| src_o | output | 5 | One-hot granted line, zero when idle |
| ext_fetch_o | output | 1 | Core must supply an external byte |
| push_pc_o | output | 1 | Save PC and branch to `vec_o` |
| vec_o | output | 16 | Branch target, valid with `push_pc_o` |

## Verification
A request that becomes eligible is latched at the next rising edge, so `pend_o` and `src_o` show it one cycle after the request was driven. `push_pc_o` and the target appear one edge after the acknowledge for fixed lines. For the external line they appear one edge after the byte that completes the target. The enable clears on the acknowledge edge itself. The bench drives inputs just after a falling edge. A behavioural model steps on the same rising edge as the design, and every output is compared on the following falling edge. The directed checks sample at the falling edge that follows the edge on which each result is due.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_REQ  = 5;
  localparam int unsigned NUM_MSK  = 3;
  localparam int unsigned SRC_EXT  = 0;
  localparam int unsigned SRC_L55  = 1;
  localparam int unsigned SRC_L65  = 2;
  localparam int unsigned SRC_L75  = 3;
  localparam int unsigned SRC_TRAP = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_OP,
    ST_LO,
    ST_HI,
    ST_ISSUE
  } irq_state_e;
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ei_i,
  input  logic               di_i,
  input  logic               ack_clr_i,
  input  logic               mask_wr_i,
  input  logic [NUM_MSK-1:0] mask_data_i,
  output logic               en_o,
  output logic [NUM_MSK-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      mask_o <= '1;
    end else begin
      // an acknowledge or DI beats a simultaneous EI
      if (ack_clr_i || di_i) en_o <= 1'b0;
      else if (ei_i)         en_o <= 1'b1;
      if (mask_wr_i) mask_o <= mask_data_i;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned          ADDR_W  = 16,
  parameter logic [ADDR_W-1:0]    TRAP_VEC = 'h24,
  parameter logic [ADDR_W-1:0]    L75_VEC  = 'h3C,
  parameter logic [ADDR_W-1:0]    L65_VEC  = 'h34,
  parameter logic [ADDR_W-1:0]    L55_VEC  = 'h2C
) (
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               en_i,
  input  logic [NUM_MSK-1:0] mask_i,
  output logic [NUM_REQ-1:0] grant_o,
  output logic               any_o,
  output logic [ADDR_W-1:0]  vec_o
);
  logic [NUM_REQ-1:0] elig;
  logic [ADDR_W-1:0]  vec_tab [NUM_REQ];

  assign elig[SRC_TRAP] = req_i[SRC_TRAP];
  assign elig[SRC_EXT]  = req_i[SRC_EXT] & en_i;

  for (genvar g = 0; g < NUM_MSK; g++) begin : g_msk
    assign elig[SRC_L55+g] = req_i[SRC_L55+g] & en_i & ~mask_i[g];
  end

  assign vec_tab[SRC_EXT]  = '0;
  assign vec_tab[SRC_L55]  = L55_VEC;
  assign vec_tab[SRC_L65]  = L65_VEC;
  assign vec_tab[SRC_L75]  = L75_VEC;
  assign vec_tab[SRC_TRAP] = TRAP_VEC;

  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    vec_o   = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (elig[i] && !found) begin
        found      = 1'b1;
        grant_o[i] = 1'b1;
        vec_o      = vec_tab[i];
      end
    end
  end

  assign any_o = |elig;
endmodule

// File: rtl/irq_ext_decoder.sv
module irq_ext_decoder #(
  parameter int unsigned       OP_W    = 8,
  parameter int unsigned       ADDR_W  = 16,
  parameter logic [OP_W-1:0]   CALL_OP = 'hCD
) (
  input  logic [OP_W-1:0]   op_i,
  output logic              is_rst_o,
  output logic              is_call_o,
  output logic [ADDR_W-1:0] rst_vec_o
);
  localparam int unsigned SLOT_W = 3;
  localparam int unsigned SLOT_LO = 3;

  assign is_rst_o  = (op_i[OP_W-1 -: 2] == 2'b11) && (op_i[SLOT_LO-1:0] == '1);
  assign is_call_o = (op_i == CALL_OP);

  always_comb begin
    rst_vec_o = '0;
    // restart slot n lands at n*8
    rst_vec_o[SLOT_LO +: SLOT_W] = op_i[SLOT_LO +: SLOT_W];
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_pkg::*;
#(
  parameter int unsigned        OP_W     = 8,
  parameter logic [2*OP_W-1:0]  TRAP_VEC = 'h24,
  parameter logic [2*OP_W-1:0]  L75_VEC  = 'h3C,
  parameter logic [2*OP_W-1:0]  L65_VEC  = 'h34,
  parameter logic [2*OP_W-1:0]  L55_VEC  = 'h2C,
  parameter logic [OP_W-1:0]    CALL_OP  = 'hCD
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REQ-1:0]  req_i,
  input  logic                ei_i,
  input  logic                di_i,
  input  logic                mask_wr_i,
  input  logic [NUM_MSK-1:0]  mask_data_i,
  input  logic                ack_i,
  input  logic                bus_valid_i,
  input  logic [OP_W-1:0]     bus_data_i,
  output logic                pend_o,
  output logic [NUM_REQ-1:0]  src_o,
  output logic                ext_fetch_o,
  output logic                push_pc_o,
  output logic [2*OP_W-1:0]   vec_o
);
  localparam int unsigned ADDR_W = 2 * OP_W;

  irq_state_e          state_q;
  logic [NUM_REQ-1:0]  src_q;
  logic [ADDR_W-1:0]   vec_q;
  logic [OP_W-1:0]     lo_q;

  logic                en_q;
  logic [NUM_MSK-1:0]  mask_q;
  logic [NUM_REQ-1:0]  grant;
  logic                grant_any;
  logic [ADDR_W-1:0]   grant_vec;
  logic                op_rst, op_call;
  logic [ADDR_W-1:0]   op_vec;
  logic                ack_clr;

  assign ack_clr = (state_q == ST_HOLD) && ack_i && !src_q[SRC_TRAP];

  irq_ctrl_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ei_i        (ei_i),
    .di_i        (di_i),
    .ack_clr_i   (ack_clr),
    .mask_wr_i   (mask_wr_i),
    .mask_data_i (mask_data_i),
    .en_o        (en_q),
    .mask_o      (mask_q)
  );

  irq_arbiter #(
    .ADDR_W   (ADDR_W),
    .TRAP_VEC (TRAP_VEC),
    .L75_VEC  (L75_VEC),
    .L65_VEC  (L65_VEC),
    .L55_VEC  (L55_VEC)
  ) i_arb (
    .req_i   (req_i),
    .en_i    (en_q),
    .mask_i  (mask_q),
    .grant_o (grant),
    .any_o   (grant_any),
    .vec_o   (grant_vec)
  );

  irq_ext_decoder #(
    .OP_W    (OP_W),
    .ADDR_W  (ADDR_W),
    .CALL_OP (CALL_OP)
  ) i_dec (
    .op_i      (bus_data_i),
    .is_rst_o  (op_rst),
    .is_call_o (op_call),
    .rst_vec_o (op_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      vec_q   <= '0;
      lo_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (grant_any) begin
          state_q <= ST_HOLD;
          src_q   <= grant;
          vec_q   <= grant_vec;
        end
        ST_HOLD: if (ack_i) state_q <= src_q[SRC_EXT] ? ST_OP : ST_ISSUE;
        ST_OP: if (bus_valid_i) begin
          if (op_rst) begin
            vec_q   <= op_vec;
            state_q <= ST_ISSUE;
          end else if (op_call) begin
            state_q <= ST_LO;
          end else begin
            state_q <= ST_IDLE;
            src_q   <= '0;
          end
        end
        ST_LO: if (bus_valid_i) begin
          lo_q    <= bus_data_i;
          state_q <= ST_HI;
        end
        ST_HI: if (bus_valid_i) begin
          vec_q   <= {bus_data_i, lo_q};
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          state_q <= ST_IDLE;
          src_q   <= '0;
        end
        default: begin
          state_q <= ST_IDLE;
          src_q   <= '0;
        end
      endcase
    end
  end

  assign pend_o      = (state_q == ST_HOLD);
  assign src_o       = src_q;
  assign ext_fetch_o = (state_q == ST_OP) || (state_q == ST_LO) || (state_q == ST_HI);
  assign push_pc_o   = (state_q == ST_ISSUE);
  assign vec_o       = push_pc_o ? vec_q : '0;
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk
  import irq_pkg::*;
#(
  parameter int unsigned        OP_W     = 8,
  parameter logic [2*OP_W-1:0]  TRAP_VEC = 'h24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic               pend_o,
  input logic [NUM_REQ-1:0] src_o,
  input logic               ext_fetch_o,
  input logic               push_pc_o,
  input logic [2*OP_W-1:0]  vec_o,
  input logic               en_q
);
  AST_SRC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_o)); // R2

  AST_GRANT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !ack_i |=> pend_o && $stable(src_o)); // R7

  AST_PUSH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_pc_o |=> !push_pc_o); // R9

  AST_ACK_CLEARS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && ack_i && !src_o[SRC_TRAP] |=> !en_q); // R8

  AST_TRAP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_pc_o && src_o[SRC_TRAP] |-> vec_o == TRAP_VEC); // R3

  AST_FETCH_EXT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_fetch_o |-> src_o[SRC_EXT] && !pend_o && !push_pc_o); // R10
endmodule

bind irq_vector_unit irq_vector_unit_chk #(
  .OP_W     (OP_W),
  .TRAP_VEC (TRAP_VEC)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_i       (ack_i),
  .pend_o      (pend_o),
  .src_o       (src_o),
  .ext_fetch_o (ext_fetch_o),
  .push_pc_o   (push_pc_o),
  .vec_o       (vec_o),
  .en_q        (en_q)
);

// File: tb/test_irq_vector_unit.sv
module test_irq_vector_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  req = '0;
  logic        ei = 1'b0, di = 1'b0, mask_wr = 1'b0, ack = 1'b0, bv = 1'b0;
  logic [2:0]  mask_data = '0;
  logic [7:0]  bus = '0;
  logic        pend_o, ext_fetch_o, push_pc_o;
  logic [4:0]  src_o;
  logic [15:0] vec_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vector_unit i_irq_vector_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ei_i(ei), .di_i(di),
    .mask_wr_i(mask_wr), .mask_data_i(mask_data), .ack_i(ack),
    .bus_valid_i(bv), .bus_data_i(bus), .pend_o(pend_o), .src_o(src_o),
    .ext_fetch_o(ext_fetch_o), .push_pc_o(push_pc_o), .vec_o(vec_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: mode 0 idle,1 waiting ack,2 opcode,3 low,4 high,5 issue
  int m_st, m_src, m_vec, m_lo;
  bit m_en;
  bit [2:0] m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_src = 0; m_vec = 0; m_lo = 0; m_en = 0; m_mask = 3'b111;
    end else begin
      bit clr;
      clr = 0;
      case (m_st)
        0: begin
          if (req[4]) begin m_src = 4; m_vec = 'h24; m_st = 1; end
          else if (m_en) begin
            if (req[3] && !m_mask[2])      begin m_src = 3; m_vec = 'h3C; m_st = 1; end
            else if (req[2] && !m_mask[1]) begin m_src = 2; m_vec = 'h34; m_st = 1; end
            else if (req[1] && !m_mask[0]) begin m_src = 1; m_vec = 'h2C; m_st = 1; end
            else if (req[0])               begin m_src = 0; m_vec = 0;    m_st = 1; end
          end
        end
        1: if (ack) begin clr = (m_src != 4); m_st = (m_src == 0) ? 2 : 5; end
        2: if (bv) begin
          if (bus[7:6] == 2'b11 && bus[2:0] == 3'b111) begin m_vec = int'(bus[5:3]) * 8; m_st = 5; end
          else if (bus == 8'hCD) m_st = 3;
          else m_st = 0;
        end
        3: if (bv) begin m_lo = int'(bus); m_st = 4; end
        4: if (bv) begin m_vec = int'(bus) * 256 + m_lo; m_st = 5; end
        default: m_st = 0;
      endcase
      if (clr || di) m_en = 0;
      else if (ei) m_en = 1;
      if (mask_wr) m_mask = mask_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 model pend_o", int'(pend_o), int'(m_st == 1));
      chk("R2 model src_o", int'(src_o), (m_st != 0) ? (1 << m_src) : 0);
      chk("R10 model ext_fetch_o", int'(ext_fetch_o), int'(m_st >= 2 && m_st <= 4));
      chk("R9 model push_pc_o", int'(push_pc_o), int'(m_st == 5));
      chk("R4 model vec_o", int'(vec_o), (m_st == 5) ? m_vec : 0);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ei();
    ei = 1'b1; tick(); ei = 1'b0;
  endtask

  task automatic set_mask(input logic [2:0] m);
    mask_wr = 1'b1; mask_data = m; tick(); mask_wr = 1'b0;
  endtask

  task automatic wait_pend(input string tag, input int exp_src);
    for (int k = 0; k < 20 && !pend_o; k++) tick();
    chk({tag, " grant pending"}, int'(pend_o), 1);
    chk({tag, " granted line"}, int'(src_o), exp_src);
  endtask

  task automatic serve_fixed(input string tag, input int exp_src, input int exp_vec);
    wait_pend(tag, exp_src);
    ack = 1'b1; req = '0; tick(); ack = 1'b0;
    chk({tag, " push"}, int'(push_pc_o), 1);
    chk({tag, " target"}, int'(vec_o), exp_vec);
    tick();
    chk("R9 push one cycle", int'(push_pc_o), 0);
  endtask

  task automatic ack_ext(input string tag);
    wait_pend(tag, 1);
    ack = 1'b1; req = '0; tick(); ack = 1'b0;
    chk("R10 ext fetch requested", int'(ext_fetch_o), 1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    chk("R1 pend_o after reset", int'(pend_o), 0);
    chk("R1 src_o after reset", int'(src_o), 0);
    chk("R1 push after reset", int'(push_pc_o), 0);
    chk("R1 vec after reset", int'(vec_o), 0);
    // enable clear after reset blocks maskable lines
    req = 5'b01111; tick(4);
    chk("R1 no grant while disabled", int'(pend_o), 0);
    // masks set after reset: only the external line may win
    pulse_ei();
    ack_ext("R6");
    bv = 1'b1; bus = 8'hEF; tick(); bv = 1'b0;
    chk("R10 restart push", int'(push_pc_o), 1);
    chk("R10 restart 5 target", int'(vec_o), 'h28);
    tick();
    // acknowledge cleared the enable
    req = 5'b00001; tick(3);
    chk("R8 maskable ack clears enable", int'(pend_o), 0);
    req = '0;

    set_mask(3'b000);
    pulse_ei(); req = 5'b01110; serve_fixed("R4 line3", 8, 'h3C);
    pulse_ei(); req = 5'b00110; serve_fixed("R4 line2", 4, 'h34);
    pulse_ei(); req = 5'b00010; serve_fixed("R4 line1", 2, 'h2C);

    // grant held while higher requests appear
    pulse_ei(); req = 5'b00010;
    wait_pend("R7", 2);
    req = 5'b11111; tick(2);
    chk("R7 still pending", int'(pend_o), 1);
    chk("R7 source held", int'(src_o), 2);
    ack = 1'b1; req = '0; tick(); ack = 1'b0;
    chk("R7 held target", int'(vec_o), 'h2C);
    tick();

    // non-maskable with enable clear and masks set
    set_mask(3'b111);
    req = 5'b10000; serve_fixed("R3 trap disabled", 16, 'h24);

    // trap beats external; trap ack leaves enable set
    pulse_ei(); req = 5'b10001; serve_fixed("R2 trap over ext", 16, 'h24);
    req = 5'b00001;
    ack_ext("R8 enable kept after trap");
    bv = 1'b1; bus = 8'hCD; tick(); bv = 1'b0;
    tick();
    chk("R11 waiting for low byte", int'(ext_fetch_o), 1);
    bv = 1'b1; bus = 8'h34; tick();
    bus = 8'h12; tick(); bv = 1'b0;
    chk("R11 call push", int'(push_pc_o), 1);
    chk("R11 call target", int'(vec_o), 'h1234);
    tick();

    // DI wins over simultaneous EI
    ei = 1'b1; di = 1'b1; tick(); ei = 1'b0; di = 1'b0;
    req = 5'b00001; tick(3);
    chk("R5 DI wins", int'(pend_o), 0);
    pulse_ei();
    ack_ext("R5 EI enables");
    bv = 1'b1; bus = 8'h3E; tick(); bv = 1'b0;
    chk("R12 no push on other opcode", int'(push_pc_o), 0);
    chk("R12 back to idle", int'(ext_fetch_o), 0);
    chk("R12 source cleared", int'(src_o), 0);
    req = 5'b00001; tick(3);
    chk("R12 enable stays clear", int'(pend_o), 0);
    req = '0;

    // restart slot 0
    pulse_ei(); req = 5'b00001;
    ack_ext("R10 slot0");
    bv = 1'b1; bus = 8'hC7; tick(); bv = 1'b0;
    chk("R10 slot0 push", int'(push_pc_o), 1);
    chk("R10 slot0 target", int'(vec_o), 0);
    tick();

    // individual masks
    set_mask(3'b010);
    pulse_ei(); req = 5'b00110; serve_fixed("R6 mask6 skips", 2, 'h2C);
    set_mask(3'b101);
    pulse_ei(); req = 5'b01110; serve_fixed("R6 mask5/7 skip", 4, 'h34);
    tick(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule